// File: doc/BRIEF.md
# Dark-Level Servo for an Image Sensor Front End

This block closes the digital half of a black-level servo loop. Each clock carries one 12-bit pixel code from the converter. A clamp-window strobe marks the shielded dark pixels at the start of a line. While the window is open, the block compares every code against a programmable target level given in quarter-LSB units. It scales the difference down by a right shift and adds it into a fractional accumulator. The integer part of the accumulator is the signed correction word that feeds an offset DAC ahead of the converter. Between windows the correction stays where it is, so the loop follows slow drift and ignores per-pixel noise.

Three controls change the loop's speed. A fast-settle bit selects a coarser step. A re-acquire bit makes any change of the analog pre-gain setting start a short burst of very coarse steps. An enable bit switches the servo off: the target register is then driven out directly as a fixed positive offset, and the accumulator keeps its content for later. The strobe polarity can be selected, so the block fits with either timing generator convention.

Top module: `obclamp_loop`

## Requirements
- R1: While rst_n is low and for the first cycle after it, the accumulator and the re-acquire counter are zero, so with the loop enabled corr_out reads 0.
- R2: The window is open when win_strobe is 0 and cfg_win_pol is 0, or when win_strobe is 1 and cfg_win_pol is 1. Only window pixels change the accumulator.
- R3: With the loop enabled, a clock whose window is closed leaves corr_out unchanged at the next cycle, whatever the pixel code.
- R4: The accumulator is a 16-bit two's-complement value in 1/16 LSB units, and corr_out is its upper 12 bits. With the fast bit clear and no re-acquire pending, each window pixel adds (target*4 - code*16) arithmetically shifted right by 6.
- R5: With cfg_fast set and no re-acquire pending, the shift is 3.
- R6: The accumulator saturates at +32767 and -32768, so corr_out never wraps. It holds at 2047 when driven upward and at -2048 (0x800) when driven downward.
- R7: With cfg_enable low, corr_out equals target_lvl shifted right by 2, zero-extended (0 to 511). Window pixels are ignored, and the accumulator resumes from its held value on re-enable.
- R8: With cfg_gain_react set, a clock on which gain_code differs from its value on the previous clock loads a counter of 32. Each later enabled window pixel uses shift 1 and decrements the counter. A new change reloads it to 32.
- R9: With cfg_gain_react clear, gain_code changes start no re-acquire, and the step stays at shift 6 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_code | input | 12 | Converter output code for the current pixel |
| win_strobe | input | 1 | Clamp-window strobe, polarity set by cfg_win_pol |
| cfg_win_pol | input | 1 | 0: strobe active low, 1: strobe active high |
| cfg_enable | input | 1 | 1: servo runs, 0: static offset from target_lvl |
| cfg_fast | input | 1 | Selects the coarser fast-settle step |
| cfg_gain_react | input | 1 | Lets pre-gain changes start a re-acquire burst |
| gain_code | input | 3 | Current analog pre-gain setting |
| target_lvl | input | 11 | Target black level, 0.25 LSB per step |
| corr_out | output | 12 | Signed correction word for the offset DAC |

## Verification
The hardest case to reach is the re-acquire burst interacting with the window: the 32-pixel budget is counted in window pixels and not in clocks. A burst can span several short windows, can be restarted by a second gain change partway through, and must run out exactly on the 32nd pixel before the normal step returns. The stimulus produces this by changing gain_code during and between windows of 5 to 20 pixels, with the reaction bit both set and clear. Saturation is reached by combining the re-acquire step with extreme target and code values, and it is then held against further window pixels.

// File: rtl/obc_pkg.sv
// Shared types for the dark-level servo.
package obc_pkg;
    // Loop step selection, ordered by increasing loop speed
    typedef enum logic [1:0] {
        STEP_NORM  = 2'd0,
        STEP_FAST  = 2'd1,
        STEP_REACQ = 2'd2
    } step_mode_e;
endpackage

// File: rtl/obc_win_qual.sv
// obc_win_qual: turns the raw clamp strobe into an active-high window flag.
// Assumes the strobe is already synchronous to the pixel clock.
module obc_win_qual #(
    parameter bit ACT_HIGH_ONLY = 1'b0   // 1: ignore pol input, strobe always active high
) (
    input  logic strobe,
    input  logic pol_high,
    output logic win_act
);
    generate
        if (ACT_HIGH_ONLY) begin : g_fixed
            // Fixed active-high qualification
            assign win_act = strobe;
        end else begin : g_prog
            // Programmable polarity: pol_high=1 means strobe high opens the window
            always_comb win_act = pol_high ? strobe : ~strobe;
        end
    endgenerate
endmodule

// File: rtl/obc_reacq_ctrl.sv
// obc_reacq_ctrl: watches the pre-gain setting and runs the re-acquire burst
// budget, which is counted in enabled window pixels. It also picks the loop
// step for the current pixel. Assumes gain_code is synchronous to clk.
module obc_reacq_ctrl
    import obc_pkg::*;
#(
    parameter int GAIN_W    = 3,
    parameter int REACQ_PIX = 32,
    localparam int CNT_W    = $clog2(REACQ_PIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] gain_code,
    input  logic              react_en,
    input  logic              upd_en,
    input  logic              fast_sel,
    output step_mode_e        step_mode,
    output logic [CNT_W-1:0]  reacq_left
);
    logic [GAIN_W-1:0] gain_prev;
    logic              gain_trig;

    // Gain-change detection; only meaningful when reaction is enabled
    always_comb gain_trig = react_en && (gain_code != gain_prev);

    // Track previous gain and count down the re-acquire budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_prev  <= gain_code;
            reacq_left <= '0;
        end else begin
            gain_prev <= gain_code;
            if (gain_trig)
                reacq_left <= CNT_W'(REACQ_PIX);
            else if (upd_en && (reacq_left != '0))
                reacq_left <= reacq_left - 1'b1;
        end
    end

    // Step choice: re-acquire beats fast, fast beats normal
    always_comb begin
        if (reacq_left != '0)
            step_mode = STEP_REACQ;
        else if (fast_sel)
            step_mode = STEP_FAST;
        else
            step_mode = STEP_NORM;
    end
endmodule

// File: rtl/obc_err_filter.sv
// obc_err_filter: forms the signed error between target and pixel code in
// accumulator units (1/2^FRAC_W LSB) and scales it by the step shift.
// Assumes FRAC_W >= TGT_FRAC_W.
module obc_err_filter
    import obc_pkg::*;
#(
    parameter int PIX_W      = 12,
    parameter int TGT_W      = 11,
    parameter int TGT_FRAC_W = 2,
    parameter int FRAC_W     = 4,
    parameter int SH_NORM    = 6,
    parameter int SH_FAST    = 3,
    parameter int SH_REACQ   = 1,
    localparam int TGT_INT_W = TGT_W - TGT_FRAC_W,
    localparam int MAG_W     = ((PIX_W > TGT_INT_W) ? PIX_W : TGT_INT_W) + FRAC_W,
    localparam int ERR_W     = MAG_W + 1
) (
    input  logic [PIX_W-1:0]        pix_code,
    input  logic [TGT_W-1:0]        target_lvl,
    input  step_mode_e              step_mode,
    output logic signed [ERR_W-1:0] delta
);
    logic signed [ERR_W-1:0] tgt_s;
    logic signed [ERR_W-1:0] pix_s;
    logic signed [ERR_W-1:0] err_s;

    // Bring target and code onto the same fractional grid
    always_comb begin
        tgt_s = $signed(ERR_W'(target_lvl)) <<< (FRAC_W - TGT_FRAC_W);
        pix_s = $signed(ERR_W'(pix_code)) <<< FRAC_W;
        err_s = tgt_s - pix_s;
    end

    // Loop gain: arithmetic right shift picked by step mode
    always_comb begin
        case (step_mode)
            STEP_REACQ: delta = err_s >>> SH_REACQ;
            STEP_FAST:  delta = err_s >>> SH_FAST;
            default:    delta = err_s >>> SH_NORM;
        endcase
    end
endmodule

// File: rtl/obc_corr_accum.sv
// obc_corr_accum: fractional correction accumulator with saturating add.
// Adds delta on each enabled window pixel and otherwise holds. Exposes the
// integer part. Assumes ERR_W <= ACC_W + 1.
module obc_corr_accum #(
    parameter int ACC_W  = 16,
    parameter int CORR_W = 12,
    parameter int ERR_W  = 17,
    localparam int SUM_W = ((ACC_W > ERR_W) ? ACC_W : ERR_W) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_en,
    input  logic signed [ERR_W-1:0] delta,
    output logic [CORR_W-1:0]       corr_int
);
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - 1;

    logic signed [ACC_W-1:0] acc;
    logic signed [SUM_W-1:0] sum;
    logic signed [ACC_W-1:0] acc_nxt;

    // Widened sum and clamp to the accumulator range
    always_comb begin
        sum = SUM_W'(acc) + SUM_W'(delta);
        if (sum > SAT_HI)
            acc_nxt = SAT_HI[ACC_W-1:0];
        else if (sum < SAT_LO)
            acc_nxt = SAT_LO[ACC_W-1:0];
        else
            acc_nxt = sum[ACC_W-1:0];
    end

    // Accumulator register: clear on reset, update on window pixels only
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (upd_en)
            acc <= acc_nxt;
    end

    // Integer part of the correction
    assign corr_int = acc[ACC_W-1 -: CORR_W];
endmodule

// File: rtl/obclamp_loop.sv
// obclamp_loop: digital dark-level servo. It compares window pixels with a
// quarter-LSB target and integrates the scaled error into a saturating
// signed correction. When disabled, it outputs the target as a static offset.
// Assumes one pixel per clock and synchronous control inputs.
module obclamp_loop
    import obc_pkg::*;
#(
    parameter int PIX_W      = 12,
    parameter int TGT_W      = 11,
    parameter int TGT_FRAC_W = 2,
    parameter int CORR_W     = 12,
    parameter int FRAC_W     = 4,
    parameter int GAIN_W     = 3,
    parameter int REACQ_PIX  = 32,
    parameter int SH_NORM    = 6,
    parameter int SH_FAST    = 3,
    parameter int SH_REACQ   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_code,
    input  logic              win_strobe,
    input  logic              cfg_win_pol,
    input  logic              cfg_enable,
    input  logic              cfg_fast,
    input  logic              cfg_gain_react,
    input  logic [GAIN_W-1:0] gain_code,
    input  logic [TGT_W-1:0]  target_lvl,
    output logic [CORR_W-1:0] corr_out
);
    localparam int ACC_W     = CORR_W + FRAC_W;
    localparam int TGT_INT_W = TGT_W - TGT_FRAC_W;
    localparam int MAG_W     = ((PIX_W > TGT_INT_W) ? PIX_W : TGT_INT_W) + FRAC_W;
    localparam int ERR_W     = MAG_W + 1;
    localparam int CNT_W     = $clog2(REACQ_PIX + 1);

    logic                    win_act;
    logic                    upd_en;
    step_mode_e              step_mode;
    logic [CNT_W-1:0]        reacq_left;
    logic signed [ERR_W-1:0] delta;
    logic [CORR_W-1:0]       acc_corr;
    logic [CORR_W-1:0]       static_ofs;

    obc_win_qual #(.ACT_HIGH_ONLY(1'b0)) win_i (
        .strobe   (win_strobe),
        .pol_high (cfg_win_pol),
        .win_act  (win_act)
    );

    // A pixel feeds the loop only inside the window with the loop running
    assign upd_en = cfg_enable && win_act;

    obc_reacq_ctrl #(.GAIN_W(GAIN_W), .REACQ_PIX(REACQ_PIX)) reacq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gain_code  (gain_code),
        .react_en   (cfg_gain_react),
        .upd_en     (upd_en),
        .fast_sel   (cfg_fast),
        .step_mode  (step_mode),
        .reacq_left (reacq_left)
    );

    obc_err_filter #(
        .PIX_W(PIX_W), .TGT_W(TGT_W), .TGT_FRAC_W(TGT_FRAC_W), .FRAC_W(FRAC_W),
        .SH_NORM(SH_NORM), .SH_FAST(SH_FAST), .SH_REACQ(SH_REACQ)
    ) filt_i (
        .pix_code   (pix_code),
        .target_lvl (target_lvl),
        .step_mode  (step_mode),
        .delta      (delta)
    );

    obc_corr_accum #(.ACC_W(ACC_W), .CORR_W(CORR_W), .ERR_W(ERR_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .delta    (delta),
        .corr_int (acc_corr)
    );

    // Static offset in whole LSB when the servo is off
    assign static_ofs = CORR_W'(target_lvl >> TGT_FRAC_W);

    // Output select between servo result and static offset
    always_comb corr_out = cfg_enable ? acc_corr : static_ofs;
endmodule

// File: rtl/obclamp_loop_chk.sv
// obclamp_loop_chk: temporal checks on the dark-level servo, bound to every
// obclamp_loop instance. Uses ports plus the accumulator integer part and the
// re-acquire counter.
module obclamp_loop_chk #(
    parameter int PIX_W     = 12,
    parameter int TGT_W     = 11,
    parameter int CORR_W    = 12,
    parameter int GAIN_W    = 3,
    parameter int REACQ_PIX = 32,
    localparam int CNT_W    = $clog2(REACQ_PIX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PIX_W-1:0]  pix_code,
    input logic              win_strobe,
    input logic              cfg_win_pol,
    input logic              cfg_enable,
    input logic              cfg_gain_react,
    input logic [GAIN_W-1:0] gain_code,
    input logic [TGT_W-1:0]  target_lvl,
    input logic [CORR_W-1:0] corr_out,
    input logic [CORR_W-1:0] acc_corr,
    input logic [CNT_W-1:0]  reacq_left
);
    localparam logic [CORR_W-1:0] CORR_MAX = {1'b0, {(CORR_W-1){1'b1}}};

    logic open_w;
    logic err_pos;
    logic err_neg;
    assign open_w  = (win_strobe == cfg_win_pol);
    assign err_pos = ({2'b00, target_lvl} * 32'd4) >= ({4'b0000, pix_code} * 32'd16);
    assign err_neg = !err_pos;

    // R3
    hold_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !open_w) |=> (!cfg_enable || corr_out == $past(corr_out)));

    // R4
    down_step_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && open_w && err_neg) |=>
        (!cfg_enable || $signed(corr_out) <= $signed($past(corr_out))));

    // R6
    pos_saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && open_w && err_pos && corr_out == CORR_MAX) |=>
        (!cfg_enable || corr_out == CORR_MAX));

    // R7
    disabled_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> $stable(acc_corr));

    // R8
    gain_change_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gain_react && gain_code != $past(gain_code)) |=> reacq_left == CNT_W'(REACQ_PIX));

    // R9
    no_react_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_gain_react && reacq_left == '0) |=> reacq_left == '0);
endmodule

bind obclamp_loop obclamp_loop_chk #(
    .PIX_W(PIX_W), .TGT_W(TGT_W), .CORR_W(CORR_W), .GAIN_W(GAIN_W), .REACQ_PIX(REACQ_PIX)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .pix_code       (pix_code),
    .win_strobe     (win_strobe),
    .cfg_win_pol    (cfg_win_pol),
    .cfg_enable     (cfg_enable),
    .cfg_gain_react (cfg_gain_react),
    .gain_code      (gain_code),
    .target_lvl     (target_lvl),
    .corr_out       (corr_out),
    .acc_corr       (acc_corr),
    .reacq_left     (reacq_left)
);

// File: tb/obclamp_loop_tb_top.sv
`timescale 1ns/1ps
module obclamp_loop_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pix_code = '0;
    logic        win_strobe = 1'b1;
    logic        cfg_win_pol = 1'b0;
    logic        cfg_enable = 1'b1;
    logic        cfg_fast = 1'b0;
    logic        cfg_gain_react = 1'b0;
    logic [2:0]  gain_code = 3'd1;
    logic [10:0] target_lvl = 11'h1EC;
    logic [11:0] corr_out;

    int n_chk = 0;
    int n_bad = 0;
    string req_tag = "R1";
    bit done = 1'b0;

    // reference model state
    int m_acc = 0;
    int m_cnt = 0;
    int m_prev = 0;

    always #2 clk = ~clk;

    obclamp_loop dut_i (
        .clk(clk), .rst_n(rst_n), .pix_code(pix_code), .win_strobe(win_strobe),
        .cfg_win_pol(cfg_win_pol), .cfg_enable(cfg_enable), .cfg_fast(cfg_fast),
        .cfg_gain_react(cfg_gain_react), .gain_code(gain_code),
        .target_lvl(target_lvl), .corr_out(corr_out)
    );

    // Model of one clock edge, from the requirements
    task automatic model_step();
        int err, sh, s;
        bit trig, act;
        if (!rst_n) begin
            m_acc = 0; m_cnt = 0; m_prev = gain_code;
            return;
        end
        trig = cfg_gain_react && (gain_code != m_prev);
        m_prev = gain_code;
        act = (win_strobe == cfg_win_pol);
        if (cfg_enable && act) begin
            sh = (m_cnt > 0) ? 1 : (cfg_fast ? 3 : 6);
            err = int'(target_lvl) * 4 - int'(pix_code) * 16;
            s = m_acc + (err >>> sh);
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            m_acc = s;
        end
        if (trig) m_cnt = 32;
        else if (cfg_enable && act && m_cnt > 0) m_cnt = m_cnt - 1;
    endtask

    function automatic int expect_out();
        if (cfg_enable) return m_acc >>> 4;
        return int'(target_lvl) >> 2;
    endfunction

    task automatic check_val(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: corr_out got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Apply current inputs for one clock and compare after the edge
    task automatic tick();
        int got;
        model_step();
        @(negedge clk);
        got = $signed(corr_out);
        check_val(req_tag, got, expect_out());
    endtask

    task automatic set_win(bit open);
        win_strobe = cfg_win_pol ? open : ~open;
    endtask

    // Lines of pixels: window of win_len at the start of each line
    task automatic run_lines(int cycles, int win_len, int line_len, int lo, int span);
        for (int i = 0; i < cycles; i++) begin
            set_win((i % line_len) < win_len);
            pix_code = 12'(lo + int'($urandom_range(span)));
            tick();
        end
    endtask

    initial begin
        int held;
        void'($urandom(32'h0B1C_5EED));
        @(negedge clk);
        // R1: reset state
        req_tag = "R1";
        for (int i = 0; i < 3; i++) begin
            set_win(1'b1); pix_code = 12'd0; tick();
        end
        rst_n = 1'b1;
        set_win(1'b0); tick();

        // R4 / R2: normal step, active-low window
        req_tag = "R4";
        run_lines(400, 20, 60, 100, 50);
        // R2: active-high window
        req_tag = "R2";
        cfg_win_pol = 1'b1;
        run_lines(200, 20, 60, 90, 80);
        cfg_win_pol = 1'b0;

        // R5: fast step
        req_tag = "R5";
        cfg_fast = 1'b1;
        run_lines(300, 12, 40, 60, 200);
        cfg_fast = 1'b0;

        // R3: closed window with wild codes leaves output alone
        req_tag = "R3";
        held = $signed(corr_out);
        for (int i = 0; i < 20; i++) begin
            set_win(1'b0); pix_code = 12'($urandom_range(4095)); tick();
            check_val("R3 hold", $signed(corr_out), held);
        end

        // R7: disabled loop gives static offset and freezes accumulator
        req_tag = "R7";
        held = $signed(corr_out);
        cfg_enable = 1'b0;
        for (int i = 0; i < 30; i++) begin
            target_lvl = 11'($urandom_range(2047));
            set_win(1'b1); pix_code = 12'($urandom_range(4095)); tick();
        end
        target_lvl = 11'h7FF; set_win(1'b1); tick();
        check_val("R7 max offset", $signed(corr_out), 511);
        target_lvl = 11'h1EC; cfg_enable = 1'b1; set_win(1'b0); tick();
        check_val("R7 resume", $signed(corr_out), held);

        // R9: gain changes ignored when reaction is off
        req_tag = "R9";
        cfg_gain_react = 1'b0;
        gain_code = 3'd3;
        run_lines(120, 20, 60, 150, 20);

        // R8: re-acquire burst over short windows, with a retrigger
        req_tag = "R8";
        cfg_gain_react = 1'b1;
        gain_code = 3'd0;
        run_lines(70, 5, 14, 40, 10);
        gain_code = 3'd2;
        run_lines(30, 7, 10, 200, 30);
        run_lines(90, 20, 30, 120, 10);

        // R6: drive to positive then negative saturation
        req_tag = "R6";
        target_lvl = 11'h7FF; gain_code = 3'd5;
        for (int i = 0; i < 20; i++) begin
            set_win(1'b1); pix_code = 12'd0; tick();
        end
        check_val("R6 top", $signed(corr_out), 2047);
        target_lvl = 11'd0; cfg_fast = 1'b1; cfg_gain_react = 1'b0;
        for (int i = 0; i < 40; i++) begin
            set_win(1'b1); pix_code = 12'hFFF; tick();
        end
        check_val("R6 bottom", $signed(corr_out), -2048);
        cfg_fast = 1'b0;

        // Mixed random: every control toggled
        req_tag = "R4 mixed";
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) cfg_fast = 1'($urandom_range(1));
            if (i % 151 == 0) cfg_gain_react = 1'($urandom_range(1));
            if (i % 211 == 0) gain_code = 3'($urandom_range(7));
            if (i % 307 == 0) cfg_enable = ($urandom_range(4) != 0);
            if (i % 401 == 0) cfg_win_pol = 1'($urandom_range(1));
            if (i % 503 == 0) target_lvl = 11'($urandom_range(2047));
            set_win((i % 50) < 18);
            pix_code = ($urandom_range(9) == 0) ? 12'($urandom_range(4095))
                                                : 12'(int'(target_lvl >> 2) + int'($urandom_range(40)) - 20);
            tick();
        end

        // R1: reset again from a nonzero state
        req_tag = "R1";
        cfg_enable = 1'b1;
        rst_n = 1'b0; tick();
        rst_n = 1'b1; set_win(1'b0); tick();
        check_val("R1 after reset", $signed(corr_out), 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule